// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a binary-search analog-to-digital converter. A start pulse, taken while the block is idle, clears the approximation register and sets its most significant bit as the first trial. The register drives an external digital-to-analog converter at all times. An external comparator answers whether the analog input lies above that trial level. On each clock the controller settles the current trial bit from that answer and sets the next lower bit as the new trial. After one decision per bit, from MSB down to LSB, the final code is latched as the result and a one-cycle done pulse is given.

The comparator polarity is fixed. A high `cmp_in` means the input is above the DAC level, and the trial bit is kept. A low value means the input is at or below the level, and the trial bit is cleared. With an ideal comparator the result is the largest code whose DAC level lies strictly below the input.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `busy`, `done`, `result` and `dac_code` are all zero.
- R2: A `start` sampled high while `busy` is low makes `busy` high on the next cycle, with `dac_code` equal to only the MSB set (binary 1 followed by WIDTH-1 zeros).
- R3: While busy, each clock settles the current trial bit: it stays 1 if `cmp_in` was 1, otherwise it becomes 0. The next lower bit is then set to 1 and the bits above are left unchanged. `dac_code` is never zero while busy.
- R4: `busy` stays high for exactly WIDTH consecutive cycles per conversion, one decision per bit.
- R5: `done` is high for exactly one cycle, in the cycle right after the last busy cycle, and `busy` is low during it.
- R6: `result` changes only when `done` rises, and keeps the final code until the next conversion completes.
- R7: A `start` sampled while `busy` is high is ignored: timing and the final code are unaffected.
- R8: With an ideal comparator (`cmp_in` = input > `dac_code`), the result is 0 for input 0, is input−1 for inputs 1 to 2^WIDTH, and is all ones above that.
- R9: While `done` is high, `dac_code` equals `result`.
- R10: While idle with no `start`, `dac_code` and `result` hold their values.
- R11: A `start` sampled in the `done` cycle begins a new conversion at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a conversion |
| cmp_in | input | 1 | Comparator answer: 1 means the input is above the DAC level |
| dac_code | output | WIDTH | Trial code driven to the external DAC |
| result | output | WIDTH | Last completed conversion code |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when a new result is available |

## Verification
The bench runs inputs at both ends of the range: zero, one, exactly full scale, and above full scale. These expose a wrong comparator polarity or an off-by-one in the keep rule, which would show up as results one code too high or as a missing saturation. It drives start pulses in the middle of a conversion and in the done cycle itself. A design that restarted on a busy start would stretch busy and corrupt the code. A design that dropped the back-to-back start would lose a conversion. Because the reference model is compared on every clock, a trial bit set one cycle late or a result that moves outside the done cycle is caught at the cycle it goes wrong.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } sar_state_t;

    typedef struct packed {
        logic load;    // start accepted: clear register and set MSB trial
        logic step;    // one bit decision this cycle
        logic finish;  // this decision is the LSB
    } sar_ctl_t;

    function automatic logic accept_start(input sar_state_t st, input logic req);
        return (st == ST_IDLE) && req;
    endfunction

endpackage

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     last_bit,
    output sar_ctl_t ctl,
    output logic     busy
);
    sar_state_t state_q, state_d;

    always_comb begin
        ctl        = '0;
        state_d    = state_q;
        ctl.load   = accept_start(state_q, start);
        ctl.step   = (state_q == ST_CONV);
        ctl.finish = ctl.step && last_bit;
        if (ctl.load)
            state_d = ST_CONV;
        else if (ctl.finish)
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign busy = (state_q == ST_CONV);
endmodule

// File: rtl/sar_pointer.sv
module sar_pointer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    output logic [WIDTH-1:0] ptr,
    output logic             last_bit
);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (load)
            ptr_q <= TOP_BIT;
        else if (step)
            ptr_q <= ptr_q >> 1;
    end

    assign ptr      = ptr_q;
    assign last_bit = ptr_q[0];
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_in,
    input  logic [WIDTH-1:0] ptr,
    output logic [WIDTH-1:0] code,
    output logic [WIDTH-1:0] code_next
);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] decided;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic set_trial;
        if (i == WIDTH - 1) begin : g_top
            assign set_trial = 1'b0;
        end else begin : g_low
            assign set_trial = ptr[i+1];
        end
        assign decided[i] = ptr[i] ? cmp_in : (set_trial | code_q[i]);
    end

    always_comb begin
        code_next = code_q;
        if (load)
            code_next = TOP_BIT;
        else if (step)
            code_next = decided;
    end

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else
            code_q <= code_next;
    end

    assign code = code_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] dac_code,
    output logic [WIDTH-1:0] result,
    output logic             busy,
    output logic             done
);
    sar_ctl_t         ctl;
    logic [WIDTH-1:0] ptr;
    logic             last_bit;
    logic [WIDTH-1:0] code_next;
    logic [WIDTH-1:0] result_q;
    logic             done_q;

    sar_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .last_bit (last_bit),
        .ctl      (ctl),
        .busy     (busy)
    );

    sar_pointer #(.WIDTH(WIDTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .step     (ctl.step),
        .ptr      (ptr),
        .last_bit (last_bit)
    );

    sar_trial_reg #(.WIDTH(WIDTH)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.load),
        .step      (ctl.step),
        .cmp_in    (cmp_in),
        .ptr       (ptr),
        .code      (dac_code),
        .code_next (code_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= ctl.finish;
            if (ctl.finish)
                result_q <= code_next;
        end
    end

    assign result = result_q;
    assign done   = done_q;
endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [WIDTH-1:0] dac_code,
    input logic [WIDTH-1:0] result,
    input logic             busy,
    input logic             done
);
    localparam int CW = $clog2(WIDTH + 1) + 1;
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [CW-1:0] SPAN = CW'(WIDTH);

    logic [CW-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst)
            busy_len <= '0;
        else if (busy)
            busy_len <= busy_len + 1'b1;
        else
            busy_len <= '0;
    end

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && dac_code == TOP_BIT));

    assert_trial_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (dac_code != '0));

    assert_busy_span_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_len == SPAN));

    assert_busy_bound_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_len < SPAN));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    assert_result_match_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (result == dac_code));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(dac_code) && $stable(result)));
endmodule

bind sar_adc_ctrl sar_adc_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .dac_code (dac_code),
    .result   (result),
    .busy     (busy),
    .done     (done)
);

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
    localparam int W = 8;
    localparam int FULL = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         cmp_in;
    logic [W-1:0] dac_code, result;
    logic         busy, done;
    int           vin = 0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    // ideal comparator
    assign cmp_in = (vin > int'(dac_code));

    sar_adc_ctrl #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .cmp_in(cmp_in),
        .dac_code(dac_code), .result(result), .busy(busy), .done(done)
    );

    // behavioural reference model
    int m_code = 0, m_res = 0, m_idx = 0;
    bit m_busy = 0, m_done = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_code = 0; m_res = 0; m_idx = 0; m_busy = 0; m_done = 0;
        end else if (m_busy) begin
            m_done = 0;
            if (!(vin > m_code))
                m_code = m_code - (1 << m_idx);
            if (m_idx == 0) begin
                m_busy = 0; m_done = 1; m_res = m_code;
            end else begin
                m_idx = m_idx - 1;
                m_code = m_code + (1 << m_idx);
            end
        end else begin
            m_done = 0;
            if (start) begin
                m_idx = W - 1; m_code = 1 << (W - 1); m_busy = 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check("R3 dac_code", int'(dac_code), m_code);
            check("R4 busy", int'(busy), int'(m_busy));
            check("R5 done", int'(done), int'(m_done));
            check("R6 result", int'(result), m_res);
        end
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int ideal(input int v);
        int best = 0;
        for (int c = 0; c < FULL; c++)
            if (c < v) best = c;
        return best;
    endfunction

    // start one conversion; optionally pulse start mid-way; check final code
    task automatic convert(input int v, input bit poke, input bit chain);
        int n = 0;
        @(negedge clk);
        vin = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        check("R2 msb trial", int'(dac_code), 1 << (W - 1));
        if (poke) begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && n < 64) begin
            @(negedge clk);
            n++;
        end
        check("R8 final code", int'(result), ideal(v));
        check("R9 dac equals result", int'(dac_code), int'(result));
        if (poke) check("R7 busy after ignored start", int'(busy), 0);
        if (chain) begin
            // R11: start sampled in the done cycle
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R11 restart busy", int'(busy), 1);
            check("R11 restart trial", int'(dac_code), 1 << (W - 1));
            n = 0;
            while (!done && n < 64) begin
                @(negedge clk);
                n++;
            end
            check("R11 restart result", int'(result), ideal(v));
        end
    endtask

    initial begin
        int hold;
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 result", int'(result), 0);
        check("R1 dac_code", int'(dac_code), 0);
        rst = 1'b0;

        convert(0, 0, 0);
        convert(1, 0, 0);
        convert(FULL, 0, 0);
        convert(FULL + 40, 0, 0);
        convert(FULL / 2, 0, 0);
        convert(FULL / 2 + 1, 0, 0);
        convert(77, 1, 0);
        convert(200, 1, 0);
        convert(33, 0, 1);

        // R10: idle with no start, input changes, outputs hold
        hold = int'(result);
        vin = 5;
        repeat (10) @(negedge clk);
        check("R10 idle result", int'(result), hold);
        check("R10 idle dac", int'(dac_code), hold);

        for (int k = 0; k < 40; k++)
            convert((k * 37 + 11) % (FULL + 8), k % 3 == 0, k % 5 == 0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule